// File: doc/BRIEF.md
# Switched-Capacitor Phase Sequencer

This block produces the digital switch controls for a two-stage switched-capacitor capacitance readout that ends in a sample/hold. It runs from the system clock and repeats a fixed frame. Each frame contains a reset/charge phase, a dead gap, an integrate phase, a second gap, a sample phase and a final gap. During the reset/charge phase the first-stage integrator is cleared and the chosen sense capacitor charges. During the integrate phase the difference charge moves onto the feedback capacitor. The sample phase captures the second-stage output.

The second stage has two gain-capacitor banks. Each bank gets its own copy of the reset and integrate phases, delayed by a fixed number of clocks. A 2-bit gain code switches each bank on or off. A further pair of delayed phases drives the dummy switches that cancel charge injection from the main switches.

Channel selects for the sense and reference capacitors become one-hot enables. All selects are latched only at the start of a frame, so a change never takes effect in the middle of a conversion. The frame length in system clocks sets the readout rate. Choose the parameters so that this rate stays at or below 50 kHz for the system clock in use.

Top module: `sc_phase_seq`

## Requirements
- R1: After reset is released, the frame repeats every P1_LEN+P2_LEN+SMP_LEN+3*DEAD_CLKS clocks. `rst_phi` is high for the first P1_LEN output cycles of each frame. The first frame's `rst_phi` is high from the first clock edge after reset release.
- R2: `int_phi` rises DEAD_CLKS clocks after `rst_phi` falls and stays high for P2_LEN clocks. `rst_phi` and `int_phi` are never high together.
- R3: `bank_a_rst` and `bank_a_int` copy `rst_phi` and `int_phi` delayed by GAIN_DLY clocks. They are active only when the latched gain code is 1 or 3.
- R4: `bank_b_rst` and `bank_b_int` copy `rst_phi` and `int_phi` delayed by GAIN_DLY clocks. They are active only when the latched gain code is 2 or 3. Gain code 0 keeps all four bank outputs low.
- R5: `sample_phi` rises DEAD_CLKS clocks after `int_phi` falls and stays high for SMP_LEN clocks. It is never high together with any integrate output.
- R6: `dummy_rst` and `dummy_int` copy `rst_phi` and `int_phi` delayed by DUMMY_DLY clocks.
- R7: `sense_en` and `ref_en` each have exactly one bit set at all times. Bit i enables channel i.
- R8: `gain_sel`, `sense_sel` and `ref_sel` are sampled only at the clock edge where `rst_phi` rises. At every other edge, their values have no effect on any output.
- R9: When a select is sampled, a `sense_sel` of N_SENSE or more, or a `ref_sel` of N_REF or more, is ignored and the previous channel stays enabled.
- R10: While `rst` is high, all phase outputs are low, the gain code is 0, and channel 0 is enabled for both sense and reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gain_sel | input | 2 | Gain code; bit 0 enables bank A, bit 1 enables bank B |
| sense_sel | input | $clog2(N_SENSE) | Sense channel index |
| ref_sel | input | $clog2(N_REF) | Reference channel index |
| rst_phi | output | 1 | Reset/charge phase |
| int_phi | output | 1 | Integrate phase |
| bank_a_rst | output | 1 | Delayed reset phase, bank A |
| bank_a_int | output | 1 | Delayed integrate phase, bank A |
| bank_b_rst | output | 1 | Delayed reset phase, bank B |
| bank_b_int | output | 1 | Delayed integrate phase, bank B |
| sample_phi | output | 1 | Sample/hold phase |
| dummy_rst | output | 1 | Dummy-switch control for the reset phase |
| dummy_int | output | 1 | Dummy-switch control for the integrate phase |
| sense_en | output | N_SENSE | One-hot sense switch enables |
| ref_en | output | N_REF | One-hot reference switch enables |

## Verification
The sequence is run with each of the four gain codes held for whole frames. This shows that each bank answers only to its own bit and that code 0 silences both banks.

In a second pattern, the selects change on every clock, which separates sampling at the frame start from sampling at any other edge. Holding out-of-range channel values shows whether they are dropped or decoded. A reset in the middle of a frame shows whether the frame counter, the delay lines and the latched selects all return to their reset state together.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

    typedef enum logic [1:0] {
        GAIN_OFF = 2'd0,
        GAIN_A   = 2'd1,
        GAIN_B   = 2'd2,
        GAIN_AB  = 2'd3
    } gain_t;

    typedef struct packed {
        logic rst;
        logic intg;
    } phase_pair_t;

    localparam int N_BANKS = 2;

    function automatic logic bank_enabled(input gain_t g, input int bank);
        if (bank == 0) return (g == GAIN_A) || (g == GAIN_AB);
        return (g == GAIN_B) || (g == GAIN_AB);
    endfunction

endpackage

// File: rtl/sc_phase_timer.sv
module sc_phase_timer
    import sc_seq_pkg::*;
#(
    parameter int P1_LEN    = 8,
    parameter int P2_LEN    = 8,
    parameter int DEAD_CLKS = 3,
    parameter int SMP_LEN   = 4
) (
    input  logic        clk,
    input  logic        rst,
    output logic        frame_start,
    output phase_pair_t main_q,
    output logic        samp_q
);
    localparam int FRAME = P1_LEN + P2_LEN + SMP_LEN + 3 * DEAD_CLKS;
    localparam int CW    = $clog2(FRAME);
    localparam logic [CW-1:0] LAST   = CW'(FRAME - 1);
    localparam logic [CW-1:0] P1_END = CW'(P1_LEN);
    localparam logic [CW-1:0] P2_BEG = CW'(P1_LEN + DEAD_CLKS);
    localparam logic [CW-1:0] P2_END = CW'(P1_LEN + DEAD_CLKS + P2_LEN);
    localparam logic [CW-1:0] SM_BEG = CW'(P1_LEN + 2 * DEAD_CLKS + P2_LEN);
    localparam logic [CW-1:0] SM_END = CW'(P1_LEN + 2 * DEAD_CLKS + P2_LEN + SMP_LEN);

    logic [CW-1:0] cnt;

    assign frame_start = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            main_q.rst  <= 1'b0;
            main_q.intg <= 1'b0;
            samp_q      <= 1'b0;
        end else begin
            cnt         <= (cnt == LAST) ? '0 : cnt + 1'b1;
            main_q.rst  <= (cnt < P1_END);
            main_q.intg <= (cnt >= P2_BEG) && (cnt < P2_END);
            samp_q      <= (cnt >= SM_BEG) && (cnt < SM_END);
        end
    end

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST) |=> frame_start) else $error("frame wrap"); // R1

endmodule

// File: rtl/sc_delay_line.sv
module sc_delay_line #(
    parameter int DEPTH = 2,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/sc_chan_latch.sv
module sc_chan_latch #(
    parameter int N  = 6,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] sel,
    output logic [N-1:0]  en
);
    logic [N-1:0] dec;
    logic         valid;

    for (genvar i = 0; i < N; i++) begin : g_dec
        assign dec[i] = (sel == SW'(i));
    end

    assign valid = |dec;

    always_ff @(posedge clk) begin
        if (rst)                 en <= N'(1);
        else if (load && valid)  en <= dec;
    end

    AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(en) == 1) else $error("enable not one-hot"); // R7
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(en)) else $error("enable moved off frame start"); // R8

endmodule

// File: rtl/sc_phase_seq.sv
module sc_phase_seq
    import sc_seq_pkg::*;
#(
    parameter int P1_LEN    = 8,
    parameter int P2_LEN    = 8,
    parameter int DEAD_CLKS = 3,
    parameter int SMP_LEN   = 4,
    parameter int GAIN_DLY  = 2,
    parameter int DUMMY_DLY = 1,
    parameter int N_SENSE   = 6,
    parameter int N_REF     = 3,
    localparam int SSW = $clog2(N_SENSE),
    localparam int RSW = $clog2(N_REF)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         gain_sel,
    input  logic [SSW-1:0]     sense_sel,
    input  logic [RSW-1:0]     ref_sel,
    output logic               rst_phi,
    output logic               int_phi,
    output logic               bank_a_rst,
    output logic               bank_a_int,
    output logic               bank_b_rst,
    output logic               bank_b_int,
    output logic               sample_phi,
    output logic               dummy_rst,
    output logic               dummy_int,
    output logic [N_SENSE-1:0] sense_en,
    output logic [N_REF-1:0]   ref_en
);
    // Delays must end inside the following dead gap.
    phase_pair_t          main_q;
    logic                 frame_start;
    logic [1:0]           gtap;
    logic [1:0]           dtap;
    gain_t                gain_l;
    logic [N_BANKS-1:0]   bk_rst;
    logic [N_BANKS-1:0]   bk_int;

    sc_phase_timer #(
        .P1_LEN(P1_LEN), .P2_LEN(P2_LEN), .DEAD_CLKS(DEAD_CLKS), .SMP_LEN(SMP_LEN)
    ) timer_i (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .main_q(main_q), .samp_q(sample_phi)
    );

    sc_delay_line #(.DEPTH(GAIN_DLY), .W(2)) gain_dly_i (
        .clk(clk), .rst(rst), .d(main_q), .q(gtap)
    );

    sc_delay_line #(.DEPTH(DUMMY_DLY), .W(2)) dummy_dly_i (
        .clk(clk), .rst(rst), .d(main_q), .q(dtap)
    );

    sc_chan_latch #(.N(N_SENSE), .SW(SSW)) sense_i (
        .clk(clk), .rst(rst), .load(frame_start), .sel(sense_sel), .en(sense_en)
    );

    sc_chan_latch #(.N(N_REF), .SW(RSW)) ref_i (
        .clk(clk), .rst(rst), .load(frame_start), .sel(ref_sel), .en(ref_en)
    );

    always_ff @(posedge clk) begin
        if (rst)              gain_l <= GAIN_OFF;
        else if (frame_start) gain_l <= gain_t'(gain_sel);
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        assign bk_rst[b] = gtap[1] & bank_enabled(gain_l, b);
        assign bk_int[b] = gtap[0] & bank_enabled(gain_l, b);
    end

    assign rst_phi    = main_q.rst;
    assign int_phi    = main_q.intg;
    assign bank_a_rst = bk_rst[0];
    assign bank_a_int = bk_int[0];
    assign bank_b_rst = bk_rst[1];
    assign bank_b_int = bk_int[1];
    assign dummy_rst  = dtap[1];
    assign dummy_int  = dtap[0];

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(rst_phi && int_phi)) else $error("phase overlap"); // R2
    AST_INT_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(int_phi) |-> !$past(rst_phi)) else $error("no dead gap"); // R2
    AST_GAIN_SWITCH_SAFE: assert property (@(posedge clk) disable iff (rst)
        !$stable(gain_l) |-> (gtap == 2'b00)) else $error("gain switched mid-pulse"); // R3
    AST_SAMPLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sample_phi |-> !(int_phi || bank_a_int || bank_b_int)) else $error("sample overlaps"); // R5
    AST_DUMMY_LAG: assert property (@(posedge clk) disable iff (rst)
        $rose(dummy_rst) |-> $past(rst_phi)) else $error("dummy leads"); // R6

endmodule

// File: tb/sc_phase_seq_tb.sv
`timescale 1ns/1ps
module sc_phase_seq_tb_top;
    localparam int P1 = 8, P2 = 8, DEAD = 3, SMP = 4, GDLY = 2, DDLY = 1;
    localparam int NS = 6, NR = 3;
    localparam int FRAME = P1 + P2 + SMP + 3 * DEAD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] gain_sel = '0;
    logic [2:0] sense_sel = '0;
    logic [1:0] ref_sel = '0;
    logic rst_phi, int_phi, bank_a_rst, bank_a_int, bank_b_rst, bank_b_int;
    logic sample_phi, dummy_rst, dummy_int;
    logic [NS-1:0] sense_en;
    logic [NR-1:0] ref_en;

    always #2.5 clk = ~clk;

    sc_phase_seq dut_i (
        .clk(clk), .rst(rst), .gain_sel(gain_sel), .sense_sel(sense_sel), .ref_sel(ref_sel),
        .rst_phi(rst_phi), .int_phi(int_phi), .bank_a_rst(bank_a_rst), .bank_a_int(bank_a_int),
        .bank_b_rst(bank_b_rst), .bank_b_int(bank_b_int), .sample_phi(sample_phi),
        .dummy_rst(dummy_rst), .dummy_int(dummy_int), .sense_en(sense_en), .ref_en(ref_en)
    );

    int tests = 0, fails = 0, n = 0;
    int mg = 0, ms = 0, mr = 0;
    int e1 = 0, e2 = 0, es = 0;
    bit h1[$], h2[$];
    bit done = 0;
    int lfsr = 32'h1ACE;

    task automatic chk(input string req, input string what, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (step %0d)", req, what, got, exp, n);
        end
    endtask

    task automatic model_reset();
        n = 0; mg = 0; ms = 0; mr = 0; e1 = 0; e2 = 0; es = 0;
        h1.delete(); h2.delete();
        for (int i = 0; i < 16; i++) begin h1.push_back(0); h2.push_back(0); end
    endtask

    task automatic model_edge();
        int p;
        n++;
        p = (n - 1) % FRAME;
        if (p == 0) begin
            mg = gain_sel;
            if (sense_sel < NS) ms = sense_sel;
            if (ref_sel < NR) mr = ref_sel;
        end
        e1 = (p < P1);
        e2 = (p >= P1 + DEAD) && (p < P1 + DEAD + P2);
        es = (p >= P1 + 2*DEAD + P2) && (p < P1 + 2*DEAD + P2 + SMP);
        h1.push_back(e1 != 0); h2.push_back(e2 != 0);
    endtask

    task automatic compare_all();
        int last;
        int ga, gb;
        last = h1.size() - 1;
        ga = mg % 2;
        gb = mg / 2;
        chk("R1", "rst_phi", rst_phi, e1);
        chk("R2", "int_phi", int_phi, e2);
        chk("R3", "bank_a_rst", bank_a_rst, ga ? h1[last-GDLY] : 0);
        chk("R3", "bank_a_int", bank_a_int, ga ? h2[last-GDLY] : 0);
        chk("R4", "bank_b_rst", bank_b_rst, gb ? h1[last-GDLY] : 0);
        chk("R4", "bank_b_int", bank_b_int, gb ? h2[last-GDLY] : 0);
        chk("R5", "sample_phi", sample_phi, es);
        chk("R6", "dummy_rst", dummy_rst, h1[last-DDLY]);
        chk("R6", "dummy_int", dummy_int, h2[last-DDLY]);
        chk("R7", "sense_en ones", $countones(sense_en), 1);
        chk("R7", "ref_en ones", $countones(ref_en), 1);
        chk("R8/R9", "sense_en", sense_en, 1 << ms);
        chk("R8/R9", "ref_en", ref_en, 1 << mr);
    endtask

    // one clock: inputs already driven at negedge
    task automatic cycle(input int g, input int s, input int r);
        gain_sel = 2'(g); sense_sel = 3'(s); ref_sel = 2'(r);
        @(posedge clk);
        if (rst) model_reset(); else model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic hold(input int g, input int s, input int r, input int frames);
        for (int i = 0; i < frames * FRAME; i++) cycle(g, s, r);
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) cycle(3, 5, 2);
        // R10: reset state
        chk("R10", "phases in reset",
            {rst_phi, int_phi, bank_a_rst, bank_a_int, bank_b_rst, bank_b_int,
             sample_phi, dummy_rst, dummy_int}, 0);
        chk("R10", "sense_en in reset", sense_en, 1);
        chk("R10", "ref_en in reset", ref_en, 1);
        rst = 1'b0;
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        do_reset(3);
        hold(0, 2, 1, 2);          // R4 gain code 0
        hold(1, 3, 2, 2);          // R3 bank A only
        hold(2, 4, 0, 2);          // R4 bank B only
        hold(3, 5, 1, 2);          // R3 R4 both banks
        hold(3, 7, 3, 2);          // R9 out-of-range selects ignored
        hold(1, 6, 3, 1);          // R9 boundary values
        for (int i = 0; i < 6 * FRAME; i++) begin  // R8 selects change every clock
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cycle(lfsr & 3, (lfsr >> 2) & 7, (lfsr >> 5) & 3);
        end
        hold(2, 1, 2, 1);
        for (int i = 0; i < 11; i++) cycle(3, 0, 0);   // stop mid-frame
        do_reset(2);                                  // R10 mid-frame reset
        hold(3, 4, 1, 2);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule